// File: doc/BRIEF.md
# Shared-EPROM Coefficient Boot Loader

This block sequences the start-up configuration load of a filter device from one byte-wide parallel EPROM that several devices share. A single device is strapped as the master. It generates the whole EPROM address: a low address field, a control-select bit one place above that field, and a 4-bit segment number above the control-select bit. It also strobes a write-enable once per transfer. Segment 0 holds the master's own data. Segments 1 up to the strapped extra-device count hold data for slave devices. The master walks them in ascending order.

Every device watches the shared bus. A slave compares the broadcast segment number with its strapped identity code and captures bytes only when the two match, so no external decoder is needed. Inside a segment, the two control-register bytes come first, read with control-select high. The coefficients follow with control-select low. The control half of each segment is otherwise unused and is skipped. Captured coefficients leave the block as a push-only write stream with `coef_we`, `coef_idx` and `coef_data`. The EPROM pace is fixed by the master's transfer timer, so this stream has no ready input and no back-pressure: the consumer must accept one write in any cycle. Once loading is complete, a run request on the master raises a filter-enable output. That output is wired to the filter-enable input of every slave.

Top module: `coef_boot_loader`

## Requirements
- R1: With `boot_src_n` low the device is master and drives `rom_addr`, `rom_ctl`, `rom_seg` and `rom_wen`. With it high the device is a slave and holds those four outputs at zero.
- R2: For each segment the master fetches exactly N_COEF+2 bytes in this order: control-select 1 at low address 0, control-select 1 at low address 1, then control-select 0 at low addresses 0 to N_COEF-1. Low addresses 2 and above in the control half are never read. Segments run from 0 up to `dev_code` in ascending order.
- R3: Each transfer lasts XFER_CYC clock cycles with the address held constant. `rom_wen` is high for exactly one cycle, at cycle XFER_CYC/2 of the transfer, so consecutive strobes are XFER_CYC cycles apart.
- R4: On the master, `load_done` rises exactly 1+(dev_code+1)·(N_COEF+2)·XFER_CYC rising edges after reset is released. It then stays high until reset, and no further strobe is issued.
- R5: `ctrl_word[7:0]` takes the byte fetched at control-select 1, low address 0. `ctrl_word[15:8]` takes the byte at control-select 1, low address 1.
- R6: A captured coefficient appears as a one-cycle `coef_we` pulse in the cycle after the strobe, with `coef_idx` equal to the low address and `coef_data` equal to the EPROM byte.
- R7: A slave captures only in the segment whose number equals its `dev_code`. When no segment matches, it writes no coefficient and `load_done` stays low.
- R8: The master captures only segment 0, even while it drives the slave segments.
- R9: A slave raises `load_done` together with the write of coefficient N_COEF-1 of its segment. The flag stays high until reset.
- R10: The master raises `fen_out` one cycle after `run_req` and `load_done` are both high, and it stays high. `filt_en` equals `fen_out` on the master and `fen_in` AND `load_done` on a slave.
- R11: During reset `rom_wen`, `coef_we`, `load_done`, `fen_out`, `filt_en` and `ctrl_word` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| boot_src_n | input | 1 | Strap: 0 = master, 1 = slave |
| dev_code | input | 4 | Master: number of extra devices; slave: own segment code (1..15) |
| rom_addr | output | LO_W | Low EPROM address (master) |
| rom_ctl | output | 1 | Control-select address bit (master) |
| rom_seg | output | 4 | Segment address bits (master) |
| rom_wen | output | 1 | Transfer strobe (master) |
| bus_addr | input | LO_W | Low address seen on the shared bus (slave) |
| bus_ctl | input | 1 | Control-select seen on the bus (slave) |
| bus_seg | input | 4 | Segment number seen on the bus (slave) |
| bus_wen | input | 1 | Strobe seen on the bus (slave) |
| rom_data | input | 8 | EPROM data byte |
| ctrl_word | output | 16 | Captured control-register bytes |
| coef_we | output | 1 | Coefficient write pulse |
| coef_idx | output | IW | Coefficient index |
| coef_data | output | 8 | Coefficient byte |
| load_done | output | 1 | Load complete (sticky) |
| run_req | input | 1 | Start request (master) |
| fen_in | input | 1 | Filter enable from master (slave) |
| fen_out | output | 1 | Filter enable for slaves (master) |
| filt_en | output | 1 | Local filter enable |

## Verification
The bench builds the block with N_COEF=6, LO_W=3 and XFER_CYC=4. With these values the last coefficient address (5) sits just below the top of a 3-bit field, while the unused control addresses 2 to 7 all exist and must be skipped. A full walk of the master and three slaves takes only a few hundred cycles. Changing the master count between runs covers a segment with no matching slave, a single-segment load and a load of every slave, and the strobe spacing of 4 gives a mid-transfer strobe with a distinct cycle on each side.

// File: rtl/cbl_pkg.sv
package cbl_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_RUN  = 2'd1,
    SEQ_DONE = 2'd2
  } seq_state_e;

  localparam int SEG_W  = 4;
  localparam int BYTE_W = 8;
endpackage

// File: rtl/cbl_sequencer.sv
module cbl_sequencer
  import cbl_pkg::*;
#(
  parameter int N_COEF   = 16,
  parameter int LO_W     = 8,
  parameter int XFER_CYC = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [SEG_W-1:0] last_seg,
  output logic [LO_W-1:0]  addr,
  output logic             ctl,
  output logic [SEG_W-1:0] seg,
  output logic             wen,
  output logic             done
);
  localparam int XW = $clog2(N_COEF + 2);
  localparam int CW = $clog2(XFER_CYC);
  localparam logic [XW-1:0] X_LAST = XW'(N_COEF + 1);
  localparam logic [CW-1:0] C_LAST = CW'(XFER_CYC - 1);
  localparam logic [CW-1:0] C_WEN  = CW'(XFER_CYC / 2);

  seq_state_e       st;
  logic [CW-1:0]    cyc;
  logic [XW-1:0]    xfer;
  logic [SEG_W-1:0] seg_q;
  logic             run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= SEQ_IDLE;
      cyc   <= '0;
      xfer  <= '0;
      seg_q <= '0;
    end else begin
      case (st)
        SEQ_IDLE: if (en) st <= SEQ_RUN;
        SEQ_RUN: begin
          if (cyc == C_LAST) begin
            cyc <= '0;
            if (xfer == X_LAST) begin
              xfer <= '0;
              if (seg_q == last_seg) st <= SEQ_DONE;
              else seg_q <= seg_q + SEG_W'(1);
            end else begin
              xfer <= xfer + XW'(1);
            end
          end else begin
            cyc <= cyc + CW'(1);
          end
        end
        default: ;
      endcase
    end
  end

  // The first two slots of a segment are the control bytes; the pad area is skipped.
  always_comb begin
    run  = (st == SEQ_RUN);
    ctl  = run && (xfer < XW'(2));
    if (!run)     addr = '0;
    else if (ctl) addr = LO_W'(xfer);
    else          addr = LO_W'(xfer - XW'(2));
    seg  = run ? seg_q : '0;
    wen  = run && (cyc == C_WEN);
    done = (st == SEQ_DONE);
  end

  // R3
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wen |-> $stable({seg, ctl, addr}));
  // R2
  ctl_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl |-> (addr < LO_W'(2)));
  // R2
  seg_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (seg <= last_seg));
  // R4
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (done && !wen));
endmodule

// File: rtl/cbl_capture.sv
module cbl_capture
  import cbl_pkg::*;
#(
  parameter int N_COEF = 16,
  parameter int LO_W   = 8,
  parameter int IW     = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              act,
  input  logic [SEG_W-1:0]  my_code,
  input  logic              wen,
  input  logic [SEG_W-1:0]  seg,
  input  logic              ctl,
  input  logic [LO_W-1:0]   addr,
  input  logic [BYTE_W-1:0] data,
  output logic [15:0]       ctrl_word,
  output logic              coef_we,
  output logic [IW-1:0]     coef_idx,
  output logic [BYTE_W-1:0] coef_data,
  output logic              seg_done
);
  localparam logic [LO_W-1:0] A_LAST = LO_W'(N_COEF - 1);

  logic hit;
  assign hit = act && wen && (seg == my_code);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_word <= '0;
      coef_we   <= 1'b0;
      coef_idx  <= '0;
      coef_data <= '0;
      seg_done  <= 1'b0;
    end else begin
      coef_we <= 1'b0;
      if (hit && ctl) begin
        if (addr == '0)              ctrl_word[7:0]  <= data;
        else if (addr == LO_W'(1))   ctrl_word[15:8] <= data;
      end
      if (hit && !ctl && (addr <= A_LAST)) begin
        coef_we   <= 1'b1;
        coef_idx  <= IW'(addr);
        coef_data <= data;
        if (addr == A_LAST) seg_done <= 1'b1;
      end
    end
  end

  // R6
  coef_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    coef_we |-> $past(hit));
  // R6
  coef_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    coef_we |-> (coef_idx <= IW'(N_COEF - 1)));
  // R9
  seg_done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seg_done |=> seg_done);
endmodule

// File: rtl/cbl_fen_ctrl.sv
module cbl_fen_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic is_master,
  input  logic all_done,
  input  logic own_done,
  input  logic run_req,
  input  logic fen_in,
  output logic fen_out,
  output logic filt_en
);
  logic fen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fen_q <= 1'b0;
    else if (is_master && all_done && run_req) fen_q <= 1'b1;
  end

  assign fen_out = fen_q;
  assign filt_en = is_master ? fen_q : (fen_in && own_done);

  // R10
  fen_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fen_out |=> fen_out);
  // R10
  fen_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fen_out) |-> $past(all_done && run_req));
endmodule

// File: rtl/coef_boot_loader.sv
module coef_boot_loader
  import cbl_pkg::*;
#(
  parameter int N_COEF   = 16,
  parameter int LO_W     = 8,
  parameter int XFER_CYC = 4,
  parameter int IW       = (N_COEF > 1) ? $clog2(N_COEF) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              boot_src_n,
  input  logic [3:0]        dev_code,
  output logic [LO_W-1:0]   rom_addr,
  output logic              rom_ctl,
  output logic [3:0]        rom_seg,
  output logic              rom_wen,
  input  logic [LO_W-1:0]   bus_addr,
  input  logic              bus_ctl,
  input  logic [3:0]        bus_seg,
  input  logic              bus_wen,
  input  logic [7:0]        rom_data,
  output logic [15:0]       ctrl_word,
  output logic              coef_we,
  output logic [IW-1:0]     coef_idx,
  output logic [7:0]        coef_data,
  output logic              load_done,
  input  logic              run_req,
  input  logic              fen_in,
  output logic              fen_out,
  output logic              filt_en
);
  logic             is_master;
  logic             seq_done;
  logic             cap_done;
  logic             cap_act;
  logic [SEG_W-1:0] cap_code;
  logic [LO_W-1:0]  v_addr;
  logic             v_ctl;
  logic [SEG_W-1:0] v_seg;
  logic             v_wen;

  assign is_master = !boot_src_n;

  cbl_sequencer #(.N_COEF(N_COEF), .LO_W(LO_W), .XFER_CYC(XFER_CYC)) u_seq (
    .clk(clk), .rst_n(rst_n), .en(is_master), .last_seg(dev_code),
    .addr(rom_addr), .ctl(rom_ctl), .seg(rom_seg), .wen(rom_wen), .done(seq_done)
  );

  // The master listens to its own outputs; a slave listens to the shared bus.
  assign v_addr   = is_master ? rom_addr : bus_addr;
  assign v_ctl    = is_master ? rom_ctl  : bus_ctl;
  assign v_seg    = is_master ? rom_seg  : bus_seg;
  assign v_wen    = is_master ? rom_wen  : bus_wen;
  assign cap_code = is_master ? '0 : dev_code;
  assign cap_act  = is_master || (dev_code != '0);

  cbl_capture #(.N_COEF(N_COEF), .LO_W(LO_W), .IW(IW)) u_cap (
    .clk(clk), .rst_n(rst_n), .act(cap_act), .my_code(cap_code),
    .wen(v_wen), .seg(v_seg), .ctl(v_ctl), .addr(v_addr), .data(rom_data),
    .ctrl_word(ctrl_word), .coef_we(coef_we), .coef_idx(coef_idx),
    .coef_data(coef_data), .seg_done(cap_done)
  );

  assign load_done = is_master ? seq_done : cap_done;

  cbl_fen_ctrl u_fen (
    .clk(clk), .rst_n(rst_n), .is_master(is_master), .all_done(seq_done),
    .own_done(cap_done), .run_req(run_req), .fen_in(fen_in),
    .fen_out(fen_out), .filt_en(filt_en)
  );

  // R1
  slave_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !is_master |-> (!rom_wen && !rom_ctl && rom_seg == '0 && rom_addr == '0));
  // R8
  master_seg0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (is_master && coef_we) |-> $past(rom_seg == '0));
endmodule

// File: tb/coef_boot_loader_test.sv
module coef_boot_loader_test;
  localparam int CLK_P = 10;
  localparam int N     = 6;
  localparam int LW    = 3;
  localparam int XC    = 4;
  localparam int IW    = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0] m_code = 4'd2;
  logic run_req = 1'b0;
  int ncheck = 0;
  int nfail  = 0;

  always #(CLK_P/2) clk = ~clk;

  logic [LW-1:0] m_addr; logic m_ctl; logic [3:0] m_seg; logic m_wen;
  logic [7:0] rdata;
  logic m_fen;
  logic [LW-1:0] s_addr[1:3]; logic s_ctl[1:3]; logic [3:0] s_seg[1:3]; logic s_wen[1:3];
  logic s_fo[1:3];
  logic          d_we[4];
  logic [IW-1:0] d_idx[4];
  logic [7:0]    d_dat[4];
  logic [15:0]   d_ctrl[4];
  logic          d_done[4];
  logic          d_fen[4];

  function automatic logic [7:0] rom_byte(input int s, input int c, input int a);
    return 8'((s * 37 + c * 101 + a * 11 + 5) % 256);
  endfunction

  assign rdata = rom_byte(int'(m_seg), int'(m_ctl), int'(m_addr));

  coef_boot_loader #(.N_COEF(N), .LO_W(LW), .XFER_CYC(XC)) uut (
    .clk(clk), .rst_n(rst_n), .boot_src_n(1'b0), .dev_code(m_code),
    .rom_addr(m_addr), .rom_ctl(m_ctl), .rom_seg(m_seg), .rom_wen(m_wen),
    .bus_addr('0), .bus_ctl(1'b0), .bus_seg(4'd0), .bus_wen(1'b0),
    .rom_data(rdata), .ctrl_word(d_ctrl[0]), .coef_we(d_we[0]),
    .coef_idx(d_idx[0]), .coef_data(d_dat[0]), .load_done(d_done[0]),
    .run_req(run_req), .fen_in(1'b0), .fen_out(m_fen), .filt_en(d_fen[0])
  );

  for (genvar g = 1; g <= 3; g++) begin : g_slv
    coef_boot_loader #(.N_COEF(N), .LO_W(LW), .XFER_CYC(XC)) slv (
      .clk(clk), .rst_n(rst_n), .boot_src_n(1'b1), .dev_code(4'(g)),
      .rom_addr(s_addr[g]), .rom_ctl(s_ctl[g]), .rom_seg(s_seg[g]), .rom_wen(s_wen[g]),
      .bus_addr(m_addr), .bus_ctl(m_ctl), .bus_seg(m_seg), .bus_wen(m_wen),
      .rom_data(rdata), .ctrl_word(d_ctrl[g]), .coef_we(d_we[g]),
      .coef_idx(d_idx[g]), .coef_data(d_dat[g]), .load_done(d_done[g]),
      .run_req(1'b0), .fen_in(m_fen), .fen_out(s_fo[g]), .filt_en(d_fen[g])
    );
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    ncheck++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Bus and capture monitors
  logic mon_on = 1'b0;
  int exp_seg, exp_x, n_xfer, since_wen, seq_err, slave_drive, cap_err;
  int exp_idx[4];
  logic [LW+4:0] prev_bus;

  always @(negedge clk) begin
    if (mon_on) begin
      since_wen++;
      for (int g = 1; g <= 3; g++)
        if (s_wen[g] || s_ctl[g] || s_seg[g] != 0 || s_addr[g] != 0) slave_drive++;
      if (m_wen) begin
        // R2 order and R3 hold/spacing
        if (int'(m_seg) != exp_seg || int'(m_ctl) != int'(exp_x < 2) ||
            int'(m_addr) != ((exp_x < 2) ? exp_x : exp_x - 2)) begin
          seq_err++;
          $display("FAIL R2 transfer %0d: actual seg %0d ctl %0d addr %0d expected seg %0d slot %0d",
                   n_xfer, m_seg, m_ctl, m_addr, exp_seg, exp_x);
        end
        if (prev_bus != {m_seg, m_ctl, m_addr}) begin
          seq_err++;
          $display("FAIL R3 address not held at strobe: actual %0h expected %0h",
                   {m_seg, m_ctl, m_addr}, prev_bus);
        end
        if (n_xfer > 0 && since_wen != XC) begin
          seq_err++;
          $display("FAIL R3 strobe spacing: actual %0d expected %0d", since_wen, XC);
        end
        since_wen = 0;
        n_xfer++;
        exp_x++;
        if (exp_x == N + 2) begin exp_x = 0; exp_seg++; end
      end
      // R6 R7 R8 coefficient writes
      for (int d = 0; d < 4; d++) begin
        if (d_we[d]) begin
          if (int'(d_idx[d]) != exp_idx[d] || d_dat[d] != rom_byte(d, 0, exp_idx[d])) begin
            cap_err++;
            $display("FAIL R6 dev %0d write: actual idx %0d data %0d expected idx %0d data %0d",
                     d, d_idx[d], d_dat[d], exp_idx[d], rom_byte(d, 0, exp_idx[d]));
          end
          exp_idx[d]++;
        end
      end
      prev_bus = {m_seg, m_ctl, m_addr};
    end
  end

  task automatic reset_check();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    // R11
    chk("R11", "rom_wen in reset", int'(m_wen), 0);
    chk("R11", "coef_we in reset", int'(d_we[0]), 0);
    chk("R11", "load_done in reset", int'(d_done[0]), 0);
    chk("R11", "fen_out in reset", int'(m_fen), 0);
    chk("R11", "filt_en in reset", int'(d_fen[0]), 0);
    chk("R11", "ctrl_word in reset", int'(d_ctrl[0]), 0);
  endtask

  task automatic load_run(input int mc, input logic rq);
    int t;
    rst_n = 1'b0;
    m_code = 4'(mc);
    run_req = rq;
    mon_on = 1'b0;
    repeat (2) @(negedge clk);
    exp_seg = 0; exp_x = 0; n_xfer = 0; since_wen = 0;
    seq_err = 0; slave_drive = 0; cap_err = 0;
    for (int d = 0; d < 4; d++) exp_idx[d] = 0;
    prev_bus = '0;
    mon_on = 1'b1;
    rst_n = 1'b1;
    t = 1 + (mc + 1) * (N + 2) * XC;
    repeat (t - 1) @(posedge clk);
    @(negedge clk);
    // R4
    chk("R4", "load_done one cycle early", int'(d_done[0]), 0);
    @(posedge clk); @(negedge clk);
    chk("R4", "load_done on time", int'(d_done[0]), 1);
    chk("R10", "fen_out same cycle as done", int'(m_fen), 0);
    @(posedge clk); @(negedge clk);
    chk("R10", "fen_out after done", int'(m_fen), int'(rq));
    repeat (3 * XC) @(negedge clk);
    chk("R4", "load_done held", int'(d_done[0]), 1);
    chk("R4", "no strobe after done", n_xfer, (mc + 1) * (N + 2));
    chk("R2", "transfer order errors", seq_err, 0);
    chk("R3", "transfer spacing", since_wen >= XC ? 1 : 0, 1);
    chk("R1", "slave drove bus", slave_drive, 0);
    chk("R6", "write content errors", cap_err, 0);
    for (int d = 0; d < 4; d++) begin
      if (d <= mc) begin
        chk(d == 0 ? "R8" : "R7", $sformatf("dev %0d writes", d), exp_idx[d], N);
        chk("R9", $sformatf("dev %0d done", d), int'(d_done[d]), 1);
        chk("R5", $sformatf("dev %0d ctrl_word", d), int'(d_ctrl[d]),
            int'({rom_byte(d, 1, 1), rom_byte(d, 1, 0)}));
      end else begin
        chk("R7", $sformatf("unmatched dev %0d writes", d), exp_idx[d], 0);
        chk("R7", $sformatf("unmatched dev %0d done", d), int'(d_done[d]), 0);
        chk("R7", $sformatf("unmatched dev %0d ctrl_word", d), int'(d_ctrl[d]), 0);
      end
    end
  endtask

  task automatic fen_test(input int mc);
    repeat (3) @(negedge clk);
    chk("R10", "fen_out idle without request", int'(m_fen), 0);
    for (int d = 0; d < 4; d++)
      chk("R10", $sformatf("dev %0d filt_en before request", d), int'(d_fen[d]), 0);
    run_req = 1'b1;
    @(posedge clk); @(negedge clk);
    chk("R10", "fen_out after request", int'(m_fen), 1);
    for (int d = 0; d < 4; d++)
      chk("R10", $sformatf("dev %0d filt_en", d), int'(d_fen[d]), int'(d <= mc));
    run_req = 1'b0;
    repeat (2) @(negedge clk);
    chk("R10", "fen_out sticky", int'(m_fen), 1);
  endtask

  logic finished = 1'b0;

  initial begin
    reset_check();
    load_run(2, 1'b0);
    fen_test(2);
    load_run(0, 1'b0);
    load_run(3, 1'b1);
    finished = 1'b1;
  end

  initial begin
    fork
      wait (finished);
      begin
        repeat (20000) @(posedge clk);
        ncheck++; nfail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", ncheck, nfail);
    $finish;
  end
endmodule